// File: doc/BRIEF.md
# Paging Pointer Entry Loader

When a guest context is entered with three-level extended paging active, this block captures the four top-level pointer entries into internal registers. It looks at three control bits: the paging-enable bit, the address-extension bit and the long-mode bit. If the mode calls for it, the block takes the entries from one of two places. With second-level translation off, it reads them from memory at the table named by the guest page-table base value being loaded. With second-level translation on, it copies them straight from four guest-state fields.

Each captured entry also carries a one-bit tag. The tag says whether the entry's value is a host-physical or a guest-physical address. This lets later translation logic use the value correctly.

A single-cycle start pulse begins a load. A single-cycle done pulse reports that the load has finished. Memory reads use a request channel with a valid/ready handshake and a response channel with a valid strobe. Only one read is outstanding at a time, and both channels may stall for any number of cycles.

Top module: `ptr_entry_loader`

## Requirements
- R1: After reset, every entry register reads 0, every tag bit reads 0, `done` is 0 and `rd_req_valid` is 0.
- R2: A start is accepted only while the loader is idle. A load happens only if `paging_on`=1, `addr_ext_on`=1 and `long_mode_on`=0 at the start cycle. Otherwise no read is issued, `done` pulses in the cycle after start, and all entries and tags keep their previous values.
- R3: If `nested_xlate_on`=1 at an accepted start, entry i is copied from `gs_entries[64i+63:64i]` in one cycle. No read is issued, all four tag bits become 1 (guest-physical), and `done` pulses in the cycle after start.
- R4: If `nested_xlate_on`=0 at an accepted start, four reads are issued in the order i=0,1,2,3. Read i goes to address (base with bits 4:0 cleared) + 8*i. Entry i, at `entries_out[64i+63:64i]`, takes the data of response i, and its tag bit i becomes 0 (host-physical).
- R5: A read request holds `rd_req_valid` high with a stable `rd_req_addr` until `rd_req_ready` is seen. Any number of wait cycles on the request channel or before `rd_rsp_valid` gives the same result.
- R6: In fetch mode, `done` is high for exactly one cycle: the cycle after the fourth entry is captured.
- R7: A start pulse that arrives while a fetch is in progress is ignored. The fetch completes with its original source, and only one `done` pulse results.
- R8: The base value is sampled at the accepted start. Changes to `base_in` during a fetch do not move the read addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle load request |
| paging_on | input | 1 | Guest paging-enable bit |
| addr_ext_on | input | 1 | Guest physical-address-extension bit |
| long_mode_on | input | 1 | Guest long-mode-enable bit |
| nested_xlate_on | input | 1 | Second-level translation enable |
| base_in | input | ADDR_W | Guest page-table base value being loaded |
| gs_entries | input | NUM_ENT*ENTRY_W | Four guest-state pointer fields, entry i at slice i |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | ENTRY_W | Read data |
| entries_out | output | NUM_ENT*ENTRY_W | Captured entries, entry i at slice i |
| guest_tag | output | NUM_ENT | Per entry: 1 guest-physical, 0 host-physical |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle. A stalled request must keep its address. Copy mode and a failed mode check must issue no read. A failed mode check must leave entries and tags untouched. Tags must follow the capture source.

Other properties can only be shown by the bench's scenarios. These are the exact read address sequence with base alignment, the data landing in the right slot, the timing of `done`, the ignoring of a mid-fetch start, and the sampling of the base at start. The bench compares these against a queue of expected reads and results under several stall patterns.

// File: rtl/ptrld_pkg.sv
package ptrld_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REQ,
      ST_WAIT
   } ld_state_e;

   function automatic logic mode_active(input logic pg, input logic pae, input logic lme);
      return pg & pae & ~lme;
   endfunction
endpackage

// File: rtl/ptrld_ctrl.sv
module ptrld_ctrl
   import ptrld_pkg::*;
#(
   parameter int ADDR_W  = 52,
   parameter int ENTRY_W = 64,
   parameter int NUM_ENT = 4,
   localparam int IDX_W  = $clog2(NUM_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_ok,
   input  logic              copy_sel,
   input  logic [ADDR_W-1:0] base_in,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   input  logic              rsp_valid,
   output logic              cap_all,
   output logic              cap_mem,
   output logic [IDX_W-1:0]  cap_idx,
   output logic              busy,
   output logic              done
);
   localparam int ENT_BYTES  = ENTRY_W / 8;
   localparam int STRIDE_LSB = $clog2(ENT_BYTES);
   localparam int TBL_LSB    = $clog2(NUM_ENT * ENT_BYTES);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << TBL_LSB) - ADDR_W'(1));

   ld_state_e         state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] base_q;
   logic              accept, last;

   assign accept    = (state_q == ST_IDLE) && start;
   assign busy      = (state_q != ST_IDLE);
   assign last      = (idx_q == IDX_W'(NUM_ENT - 1));
   assign req_valid = (state_q == ST_REQ);
   assign req_addr  = (base_q & ALIGN_MASK) | (ADDR_W'(idx_q) << STRIDE_LSB);
   assign cap_all   = accept && mode_ok && copy_sel;
   assign cap_mem   = (state_q == ST_WAIT) && rsp_valid;
   assign cap_idx   = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         base_q  <= '0;
         done    <= 1'b0;
      end else begin
         done <= (accept && (!mode_ok || copy_sel)) || (cap_mem && last);
         unique case (state_q)
            ST_IDLE: begin
               if (accept && mode_ok && !copy_sel) begin
                  base_q  <= base_in;
                  idx_q   <= '0;
                  state_q <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_valid) begin
                  if (last) begin
                     state_q <= ST_IDLE;
                  end else begin
                     idx_q   <= idx_q + IDX_W'(1);
                     state_q <= ST_REQ;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R5: a stalled request keeps its address
   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
   // R3: copy mode issues no read
   a_r3_copy_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && mode_ok && copy_sel) |=> !req_valid);
   // R2: failed mode check issues no read
   a_r2_gate_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !mode_ok) |=> !req_valid);
endmodule

// File: rtl/ptrld_regs.sv
module ptrld_regs #(
   parameter int ENTRY_W = 64,
   parameter int NUM_ENT = 4,
   localparam int IDX_W  = $clog2(NUM_ENT)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cap_all,
   input  logic [NUM_ENT*ENTRY_W-1:0] copy_data,
   input  logic                       cap_mem,
   input  logic [IDX_W-1:0]           cap_idx,
   input  logic [ENTRY_W-1:0]         mem_data,
   output logic [NUM_ENT*ENTRY_W-1:0] ent_q,
   output logic [NUM_ENT-1:0]         tag_q
);
   for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q[i*ENTRY_W +: ENTRY_W] <= '0;
            tag_q[i]                    <= 1'b0;
         end else if (cap_all) begin
            ent_q[i*ENTRY_W +: ENTRY_W] <= copy_data[i*ENTRY_W +: ENTRY_W];
            tag_q[i]                    <= 1'b1;
         end else if (cap_mem && (cap_idx == IDX_W'(i))) begin
            ent_q[i*ENTRY_W +: ENTRY_W] <= mem_data;
            tag_q[i]                    <= 1'b0;
         end
      end
   end

   // R3: a copy marks every entry guest-physical
   a_r3_tag_guest: assert property (@(posedge clk) disable iff (!rst_n)
      cap_all |=> (&tag_q));
   // R4: a fetched entry is marked host-physical
   a_r4_tag_host: assert property (@(posedge clk) disable iff (!rst_n)
      cap_mem |=> !tag_q[$past(cap_idx)]);
endmodule

// File: rtl/ptr_entry_loader.sv
module ptr_entry_loader
   import ptrld_pkg::*;
#(
   parameter int ADDR_W  = 52,
   parameter int ENTRY_W = 64,
   parameter int NUM_ENT = 4,
   localparam int IDX_W  = $clog2(NUM_ENT)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       paging_on,
   input  logic                       addr_ext_on,
   input  logic                       long_mode_on,
   input  logic                       nested_xlate_on,
   input  logic [ADDR_W-1:0]          base_in,
   input  logic [NUM_ENT*ENTRY_W-1:0] gs_entries,
   output logic                       rd_req_valid,
   input  logic                       rd_req_ready,
   output logic [ADDR_W-1:0]          rd_req_addr,
   input  logic                       rd_rsp_valid,
   input  logic [ENTRY_W-1:0]         rd_rsp_data,
   output logic [NUM_ENT*ENTRY_W-1:0] entries_out,
   output logic [NUM_ENT-1:0]         guest_tag,
   output logic                       done
);
   if (NUM_ENT < 2 || (NUM_ENT & (NUM_ENT - 1)) != 0) begin : g_bad_num
      $error("NUM_ENT must be a power of two of at least 2");
   end
   if (ENTRY_W < 8 || (ENTRY_W & (ENTRY_W - 1)) != 0) begin : g_bad_entry
      $error("ENTRY_W must be a power of two of at least 8");
   end
   if (ADDR_W <= $clog2(NUM_ENT * ENTRY_W / 8)) begin : g_bad_addr
      $error("ADDR_W too narrow for the table");
   end

   logic             mode_ok, cap_all, cap_mem, busy;
   logic [IDX_W-1:0] cap_idx;

   assign mode_ok = mode_active(paging_on, addr_ext_on, long_mode_on);

   ptrld_ctrl #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .NUM_ENT(NUM_ENT)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode_ok   (mode_ok),
      .copy_sel  (nested_xlate_on),
      .base_in   (base_in),
      .req_valid (rd_req_valid),
      .req_ready (rd_req_ready),
      .req_addr  (rd_req_addr),
      .rsp_valid (rd_rsp_valid),
      .cap_all   (cap_all),
      .cap_mem   (cap_mem),
      .cap_idx   (cap_idx),
      .busy      (busy),
      .done      (done)
   );

   ptrld_regs #(.ENTRY_W(ENTRY_W), .NUM_ENT(NUM_ENT)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_all   (cap_all),
      .copy_data (gs_entries),
      .cap_mem   (cap_mem),
      .cap_idx   (cap_idx),
      .mem_data  (rd_rsp_data),
      .ent_q     (entries_out),
      .tag_q     (guest_tag)
   );

   // R2: a rejected mode leaves captured state untouched
   a_r2_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !mode_ok) |=> ($stable(entries_out) && $stable(guest_tag)));
endmodule

// File: tb/test_ptr_entry_loader.sv
module test_ptr_entry_loader;
   localparam int AW = 52;
   localparam int EW = 64;
   localparam int NE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, pg = 1'b0, pae = 1'b0, lme = 1'b0, nst = 1'b0;
   logic [AW-1:0]    base = '0;
   logic [NE*EW-1:0] gs = '0;
   logic             req_valid, req_ready = 1'b0;
   logic [AW-1:0]    req_addr;
   logic             rsp_valid = 1'b0;
   logic [EW-1:0]    rsp_data = '0;
   logic [NE*EW-1:0] ent;
   logic [NE-1:0]    tag;
   logic             done;

   always #10 clk = ~clk;

   ptr_entry_loader #(.ADDR_W(AW), .ENTRY_W(EW), .NUM_ENT(NE)) i_ptr_entry_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .paging_on(pg), .addr_ext_on(pae),
      .long_mode_on(lme), .nested_xlate_on(nst), .base_in(base), .gs_entries(gs),
      .rd_req_valid(req_valid), .rd_req_ready(req_ready), .rd_req_addr(req_addr),
      .rd_rsp_valid(rsp_valid), .rd_rsp_data(rsp_data), .entries_out(ent),
      .guest_tag(tag), .done(done)
   );

   int n_tests = 0, n_fail = 0;
   int ndone = 0, nhs = 0;
   logic [31:0] seed = 32'h0;
   int rdy_wait = 0, rsp_wait = 0;

   logic [AW-1:0]    exp_addr_q[$];
   logic [NE*EW-1:0] exp_ent_q[$];
   logic [NE-1:0]    exp_tag_q[$];
   string            exp_req_q[$];
   logic [NE*EW-1:0] cur_ent = '0;
   logic [NE-1:0]    cur_tag = '0;

   function automatic logic [EW-1:0] mem_word(input logic [AW-1:0] a);
      return {seed, a[31:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // handshake capture at the edge
   logic          hs = 1'b0;
   logic [AW-1:0] hs_addr = '0;
   always @(posedge clk) begin
      hs      <= req_valid && req_ready;
      hs_addr <= req_addr;
   end

   // memory responder and address monitor
   int rdy_cnt = 0, rsp_cnt = 0;
   bit pend = 0;
   logic [AW-1:0] pend_addr = '0;
   initial begin
      forever begin
         @(negedge clk);
         rsp_valid = 1'b0;
         if (hs) begin
            nhs++;
            if (exp_addr_q.size() == 0)
               chk(0, "R4", "unexpected read", 256'(hs_addr), 256'(0));
            else begin
               logic [AW-1:0] ea;
               ea = exp_addr_q.pop_front();
               chk(hs_addr == ea, "R4", "read address", 256'(hs_addr), 256'(ea));
            end
            pend = 1; rsp_cnt = rsp_wait; pend_addr = hs_addr;
         end
         if (pend) begin
            if (rsp_cnt == 0) begin
               rsp_valid = 1'b1; rsp_data = mem_word(pend_addr); pend = 0;
            end else rsp_cnt--;
         end
         if (req_valid) begin
            if (rdy_cnt == 0) req_ready = 1'b1;
            else begin req_ready = 1'b0; rdy_cnt--; end
         end else begin
            req_ready = 1'b0; rdy_cnt = rdy_wait;
         end
      end
   end

   // result monitor
   bit last_done = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            ndone++;
            chk(!last_done, "R6", "done longer than one cycle", 256'(1), 256'(0));
            if (exp_ent_q.size() == 0)
               chk(0, "R6", "unexpected done", 256'(1), 256'(0));
            else begin
               logic [NE*EW-1:0] ee;
               logic [NE-1:0]    et;
               string            rq;
               ee = exp_ent_q.pop_front(); et = exp_tag_q.pop_front(); rq = exp_req_q.pop_front();
               chk(ent == ee, rq, "entries", ent, ee);
               chk(tag == et, rq, "tags", 256'(tag), 256'(et));
            end
         end
         last_done = done;
      end
   end

   // driver: pushes expectations, then pulses start
   // disturb=1: during the fetch, change base, select copy mode and pulse start (R7, R8)
   task automatic run_load(input bit p, input bit a, input bit l, input bit n,
                           input logic [AW-1:0] b, input logic [NE*EW-1:0] g,
                           input int rw, input int sw, input bit disturb, input string req);
      int d0, h0;
      bit fetch;
      rdy_wait = rw; rsp_wait = sw; seed = seed + 32'h1111_0001;
      pg = p; pae = a; lme = l; nst = n; base = b; gs = g;
      fetch = 0;
      if (p && a && !l) begin
         if (n) begin cur_ent = g; cur_tag = '1; end
         else begin
            fetch = 1;
            for (int i = 0; i < NE; i++) begin
               logic [AW-1:0] ad;
               ad = (b & ~AW'(31)) + AW'(8 * i);
               exp_addr_q.push_back(ad);
               cur_ent[i*EW +: EW] = mem_word(ad);
            end
            cur_tag = '0;
         end
      end
      exp_ent_q.push_back(cur_ent); exp_tag_q.push_back(cur_tag); exp_req_q.push_back(req);
      d0 = ndone; h0 = nhs;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (disturb) begin
         repeat (2) @(negedge clk);
         base = b ^ AW'(32'h0004_0000); nst = 1'b1; gs = ~g; start = 1'b1;
         @(negedge clk); start = 1'b0; nst = n;
      end
      while (ndone == d0) @(negedge clk);
      repeat (8) @(negedge clk);
      chk(ndone == d0 + 1, disturb ? "R7" : "R6", "done count", 256'(ndone - d0), 256'(1));
      if (!fetch)
         chk(nhs == h0, n ? "R3" : "R2", "reads issued", 256'(nhs - h0), 256'(0));
      chk(exp_addr_q.size() == 0, "R4", "reads missing", 256'(exp_addr_q.size()), 256'(0));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R6 watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   logic [NE*EW-1:0] gA, gB;
   initial begin
      gA = {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
            64'h9999_AAAA_BBBB_CCCC, 64'hDDDD_EEEE_FFFF_0123};
      gB = {64'h0F0F_0F0F_0F0F_0F0F, 64'hF0F0_F0F0_F0F0_F0F0,
            64'h1234_5678_9ABC_DEF0, 64'hCAFE_BABE_DEAD_BEEF};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ent == '0, "R1", "entries after reset", ent, 0);
      chk(tag == '0, "R1", "tags after reset", 256'(tag), 0);
      chk(!done, "R1", "done after reset", 256'(done), 0);
      chk(!req_valid, "R1", "read valid after reset", 256'(req_valid), 0);
      // R4 fetch, aligned base, no stalls
      run_load(1, 1, 0, 0, AW'(64'h0_0012_3400), gA, 0, 0, 0, "R4");
      // R4 R5 unaligned base bits, stalls on both channels
      run_load(1, 1, 0, 0, AW'(64'h0_00AB_CD1F), gA, 2, 3, 0, "R5");
      run_load(1, 1, 0, 0, AW'(64'hF_FFFF_FFE7), gA, 5, 0, 0, "R5");
      // R3 copy mode
      run_load(1, 1, 0, 1, AW'(64'h0_0000_1000), gA, 0, 0, 0, "R3");
      // R2 mode rejected three ways: entries stay at copy result
      run_load(0, 1, 0, 0, AW'(64'h0_0000_2000), gB, 0, 0, 0, "R2");
      run_load(1, 0, 0, 1, AW'(64'h0_0000_2000), gB, 0, 0, 0, "R2");
      run_load(1, 1, 1, 0, AW'(64'h0_0000_2000), gB, 0, 0, 0, "R2");
      // R4 fetch again replaces guest tags with host tags
      run_load(1, 1, 0, 0, AW'(64'h0_7654_3200), gB, 1, 1, 0, "R4");
      // R3 copy of a second pattern
      run_load(1, 1, 0, 1, AW'(64'h0_0000_0000), gB, 0, 0, 0, "R3");
      // R7 R8 mid-fetch start and base change are ignored
      run_load(1, 1, 0, 0, AW'(64'h0_0BAD_0040), gA, 3, 2, 1, "R8");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule